// File: doc/BRIEF.md
# Shutdown and Wake-up Controller

This block sits in the always-on domain, clocked by a 32768 Hz slow clock. Software stops the main supply by writing a password-guarded command over a small 32-bit register bus. The supply-enable output then drops. It comes back when an enabled wake source fires. The wake sources are up to sixteen wake pins and an RTC alarm line.

Each pin has its own enable bit and its own active level. Pin events pass through a per-pin debounce counter, and one shared selector sets the counter length. The RTC alarm is not debounced. When the wake happens, the block latches which sources were active into a status register that clears when read.

The pins and the alarm must be synchronous to the slow clock; any resynchronisation happens upstream. The bus is a strobe interface sampled on the rising clock edge, and read data is a combinational function of the address.

Top module: `pwr_sleep_ctl`

## Requirements
- R1: After reset, supply_en is 1 and every register reads 0, including status.
- R2: A write to byte offset 0x00 with data bits 31:24 equal to 0xA5 and bit 0 set, while the controller is running, drops supply_en at the next clock edge.
- R3: A write to offset 0x00 with any other key, or with bit 0 clear, leaves supply_en at 1.
- R4: Offset 0x04 holds a 3-bit debounce selector in bits 26:24 and the RTC wake enable in bit 17. Reads return these fields and zero in every other bit.
- R5: Offset 0x0C holds pin enables in bits 15:0, one bit per pin (bit i for pin i). Bits 31:16 hold the active levels, with bit 16+i for pin i, where 1 means active high and 0 means active low. The register reads back as written.
- R6: A pin qualifies once it has been at its active level for N consecutive clock edges. Selector values 0 to 5 give N = 0, 3, 32, 512, 4096 and 32768, and values 6 and 7 give 32768. With N = 0 the pin qualifies as soon as it is active. As a result, supply_en returns N+1 edges after an enabled pin goes active in shutdown.
- R7: Any edge at which a pin is at its inactive level restarts that pin's count from zero.
- R8: In shutdown, an enabled qualified pin raises supply_en at the next edge. It also sets status bit 16+i (offset 0x08) for every pin i that is enabled and qualified at that edge.
- R9: In shutdown, with the RTC enable set, a high rtc_alarm raises supply_en at the next edge and sets status bit 5.
- R10: Disabled pins, a disabled RTC alarm, and any activity while the supply is on never wake the block and never set status bits.
- R11: A read of offset 0x08 returns the status and clears it at that edge. A wake cause latched at the same edge is kept for the next read.
- R12: After a wake, the controller is running again one edge later and accepts a new shutdown command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32768 Hz slow clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives clear-on-read) |
| bus_addr | input | 4 | Byte address; bits 3:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| wake_pin | input | 16 | Wake-up pins, synchronous to clk |
| rtc_alarm | input | 1 | RTC alarm level |
| supply_en | output | 1 | Main supply enable, 1 = supply on |

## Verification
The hardest case to reach is the 32768-edge debounce window under a live shutdown. The stimulus gets there by holding a pin active for the whole window and counting edges until supply_en returns, which needs tens of thousands of cycles in a single test. Another hard case is the same-edge collision between a status read and a new wake cause. The bench creates it by making the pin qualify with selector 0 in the very cycle that carries the read strobe. The restart rule is reached by dropping a pin for one edge partway through a count, then measuring the full latency again. A behavioural reference model follows every edge, so each of these sequences is also compared cycle by cycle.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;

    typedef enum logic [1:0] {
        ST_ON   = 2'd0,
        ST_DOWN = 2'd1,
        ST_WAKE = 2'd2
    } pwr_state_e;

    typedef enum logic [1:0] {
        W_CTRL = 2'd0,
        W_MODE = 2'd1,
        W_STAT = 2'd2,
        W_WUIR = 2'd3
    } reg_word_e;

    localparam logic [7:0] SHUT_KEY     = 8'hA5;
    localparam int         KEY_LSB      = 24;
    localparam int         SEL_LSB      = 24;
    localparam int         SEL_W        = 3;
    localparam int         RTC_EN_BIT   = 17;
    localparam int         POL_LSB      = 16;
    localparam int         RTC_STAT_BIT = 5;
    localparam int         PIN_STAT_LSB = 16;

    // debounce length in slow-clock edges for a selector value
    function automatic logic [31:0] dbc_len(input logic [SEL_W-1:0] sel);
        case (sel)
            3'd0:    return 32'd0;
            3'd1:    return 32'd3;
            3'd2:    return 32'd32;
            3'd3:    return 32'd512;
            3'd4:    return 32'd4096;
            default: return 32'd32768;
        endcase
    endfunction

endpackage

// File: rtl/wake_filter.sv
module wake_filter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin,
    input  logic             active_high,
    input  logic [CNT_W-1:0] limit,
    output logic             qual
);

    logic             active;
    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign active = active_high ? pin : ~pin;

    always_comb begin
        cnt_d = '0;
        if (active) begin
            cnt_d = (cnt_q >= limit) ? limit : cnt_q + 1'b1;
        end
    end

    assign qual = (limit == '0) ? active : (cnt_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R7: an inactive edge clears the run length
    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (cnt_q == '0));

    // R6: the count never runs past the window it was sampled against
    p_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> (cnt_q <= $past(limit)));

endmodule

// File: rtl/sleep_seq.sv
module sleep_seq
    import pwr_sleep_pkg::*;
#(
    parameter int NUM_PINS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shut_cmd,
    input  logic [NUM_PINS-1:0] pin_hits,
    input  logic                rtc_hit,
    input  logic                clr_status,
    output logic                supply_en,
    output logic [NUM_PINS-1:0] stat_pins,
    output logic                stat_rtc
);

    typedef struct packed {
        pwr_state_e          state;
        logic [NUM_PINS-1:0] pins;
        logic                rtc;
    } seq_t;

    seq_t seq_d, seq_q;
    logic wake_now;

    assign wake_now = (seq_q.state == ST_DOWN) && ((|pin_hits) || rtc_hit);

    always_comb begin
        seq_d = seq_q;
        if (clr_status) begin
            seq_d.pins = '0;
            seq_d.rtc  = 1'b0;
        end
        case (seq_q.state)
            ST_ON: begin
                if (shut_cmd) seq_d.state = ST_DOWN;
            end
            ST_DOWN: begin
                if (wake_now) begin
                    seq_d.state = ST_WAKE;
                    seq_d.pins  = seq_d.pins | pin_hits;
                    seq_d.rtc   = seq_d.rtc | rtc_hit;
                end
            end
            default: seq_d.state = ST_ON;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state <= ST_ON;
            seq_q.pins  <= '0;
            seq_q.rtc   <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign supply_en = (seq_q.state != ST_DOWN);
    assign stat_pins = seq_q.pins;
    assign stat_rtc  = seq_q.rtc;

    // R8: a qualified source in shutdown restores supply and records a cause
    p_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((seq_q.state == ST_DOWN) && (|pin_hits)) |=> (supply_en && (|seq_q.pins)));

    // R9: RTC alarm wake sets its status flag
    p_rtc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((seq_q.state == ST_DOWN) && rtc_hit) |=> (supply_en && seq_q.rtc));

    // R10: new pin status bits appear only out of shutdown
    p_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(seq_q.pins & ~$past(seq_q.pins))) |-> ($past(seq_q.state) == ST_DOWN));

    // R12: the wake state lasts a single edge
    p_wake_one_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_WAKE) |=> (seq_q.state == ST_ON));

endmodule

// File: rtl/pwr_sleep_ctl.sv
module pwr_sleep_ctl
    import pwr_sleep_pkg::*;
#(
    parameter int NUM_PINS = 16,
    parameter int CNT_W    = 16,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] wake_pin,
    input  logic                rtc_alarm,
    output logic                supply_en
);

    localparam int WORD_LSB = 2;

    typedef struct packed {
        logic [SEL_W-1:0]    sel;
        logic                rtc_en;
        logic [NUM_PINS-1:0] en;
        logic [NUM_PINS-1:0] pol;
    } cfg_t;

    cfg_t                cfg_d, cfg_q;
    reg_word_e           word;
    logic                shut_cmd;
    logic                clr_status;
    logic [31:0]         len_full;
    logic [CNT_W-1:0]    limit;
    logic [NUM_PINS-1:0] qual;
    logic [NUM_PINS-1:0] pin_hits;
    logic                rtc_hit;
    logic [NUM_PINS-1:0] stat_pins;
    logic                stat_rtc;

    assign word       = reg_word_e'(bus_addr[WORD_LSB +: 2]);
    assign shut_cmd   = bus_wr && (word == W_CTRL) &&
                        (bus_wdata[KEY_LSB +: 8] == SHUT_KEY) && bus_wdata[0];
    assign clr_status = bus_rd && (word == W_STAT);

    always_comb begin
        cfg_d = cfg_q;
        if (bus_wr) begin
            case (word)
                W_MODE: begin
                    cfg_d.sel    = bus_wdata[SEL_LSB +: SEL_W];
                    cfg_d.rtc_en = bus_wdata[RTC_EN_BIT];
                end
                W_WUIR: begin
                    cfg_d.en  = bus_wdata[NUM_PINS-1:0];
                    cfg_d.pol = bus_wdata[POL_LSB +: NUM_PINS];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign len_full = dbc_len(cfg_q.sel);
    assign limit    = len_full[CNT_W-1:0];

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        wake_filter #(.CNT_W(CNT_W)) filt_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .pin         (wake_pin[g]),
            .active_high (cfg_q.pol[g]),
            .limit       (limit),
            .qual        (qual[g])
        );
    end

    assign pin_hits = qual & cfg_q.en;
    assign rtc_hit  = cfg_q.rtc_en & rtc_alarm;

    sleep_seq #(.NUM_PINS(NUM_PINS)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .shut_cmd   (shut_cmd),
        .pin_hits   (pin_hits),
        .rtc_hit    (rtc_hit),
        .clr_status (clr_status),
        .supply_en  (supply_en),
        .stat_pins  (stat_pins),
        .stat_rtc   (stat_rtc)
    );

    always_comb begin
        bus_rdata = '0;
        case (word)
            W_MODE: begin
                bus_rdata[SEL_LSB +: SEL_W] = cfg_q.sel;
                bus_rdata[RTC_EN_BIT]       = cfg_q.rtc_en;
            end
            W_STAT: begin
                bus_rdata[PIN_STAT_LSB +: NUM_PINS] = stat_pins;
                bus_rdata[RTC_STAT_BIT]             = stat_rtc;
            end
            W_WUIR: begin
                bus_rdata[NUM_PINS-1:0]       = cfg_q.en;
                bus_rdata[POL_LSB +: NUM_PINS] = cfg_q.pol;
            end
            default: ;
        endcase
    end

    // R2: supply only drops right after a correctly keyed command
    p_key_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(supply_en) |-> $past(bus_wr && (bus_addr[WORD_LSB +: 2] == 2'd0) &&
                                   (bus_wdata[KEY_LSB +: 8] == SHUT_KEY) && bus_wdata[0]));

    // R3: a badly keyed control write leaves a running supply on
    p_bad_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr[WORD_LSB +: 2] == 2'd0) && supply_en &&
         ((bus_wdata[KEY_LSB +: 8] != SHUT_KEY) || !bus_wdata[0])) |=> supply_en);

endmodule

// File: tb/pwr_sleep_ctl_tb_top.sv
module pwr_sleep_ctl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] wake_pin = '0;
    logic        rtc_alarm = 1'b0;
    logic        supply_en;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_sleep_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wake_pin(wake_pin), .rtc_alarm(rtc_alarm), .supply_en(supply_en)
    );

    // ---------------- reference model ----------------
    int          m_cnt [16];
    int          m_state;     // 0 running, 1 shutdown, 2 waking
    logic [2:0]  m_sel;
    logic        m_rtc_en;
    logic [15:0] m_en, m_pol, m_hits;
    logic [31:0] m_stat;
    int          m_n;
    logic        m_act, m_rt;

    function automatic int len_of(input logic [2:0] s);
        case (s)
            3'd0: return 0;
            3'd1: return 3;
            3'd2: return 32;
            3'd3: return 512;
            3'd4: return 4096;
            default: return 32768;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) m_cnt[i] = 0;
            m_state = 0; m_sel = '0; m_rtc_en = 1'b0;
            m_en = '0; m_pol = '0; m_stat = '0;
        end else begin
            m_n    = len_of(m_sel);
            m_hits = '0;
            for (int i = 0; i < 16; i++) begin
                m_act = m_pol[i] ? wake_pin[i] : !wake_pin[i];
                if (m_en[i] && ((m_n == 0) ? m_act : (m_cnt[i] >= m_n))) m_hits[i] = 1'b1;
                if (m_act) m_cnt[i] = (m_cnt[i] + 1 > m_n) ? m_n : m_cnt[i] + 1;
                else       m_cnt[i] = 0;
            end
            m_rt = m_rtc_en && rtc_alarm;
            if (bus_rd && bus_addr[3:2] == 2'd2) m_stat = '0;
            if (m_state == 1 && (m_hits != 0 || m_rt)) begin
                m_stat = m_stat | {m_hits, 16'h0} | (m_rt ? 32'h20 : 32'h0);
                m_state = 2;
            end else if (m_state == 2) begin
                m_state = 0;
            end else if (m_state == 0 && bus_wr && bus_addr[3:2] == 2'd0 &&
                         bus_wdata[31:24] == 8'hA5 && bus_wdata[0]) begin
                m_state = 1;
            end
            if (bus_wr && bus_addr[3:2] == 2'd1) begin
                m_sel = bus_wdata[26:24]; m_rtc_en = bus_wdata[17];
            end
            if (bus_wr && bus_addr[3:2] == 2'd3) begin
                m_en = bus_wdata[15:0]; m_pol = bus_wdata[31:16];
            end
        end
    end

    function automatic logic [31:0] model_rdata(input logic [3:0] a);
        case (a[3:2])
            2'd1: return {5'b0, m_sel, 6'b0, m_rtc_en, 17'b0};
            2'd2: return m_stat;
            2'd3: return {m_pol, m_en};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // every-cycle comparison against the model, away from the clock edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(supply_en == (m_state != 1), "R2 R8 R12 supply_en per cycle",
                  {31'b0, supply_en}, {31'b0, m_state != 1});
            check(bus_rdata == model_rdata(bus_addr), "R4 R5 R11 rdata per cycle",
                  bus_rdata, model_rdata(bus_addr));
        end
    end

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT) begin
            n_fails++;
            $display("FAIL watchdog (R6 R12): actual %0d cycles expected below %0d", cycles, WD_LIMIT);
            finish_run();
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        cyc();
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic peek(input logic [3:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        @(negedge clk);
        check(bus_rdata == exp, tag, bus_rdata, exp);
        @(posedge clk); #1;
    endtask

    task automatic read_clear(input logic [31:0] exp, input string tag);
        bus_addr = 4'h8; bus_rd = 1'b1;
        @(negedge clk);
        check(bus_rdata == exp, tag, bus_rdata, exp);
        @(posedge clk); #1;
        bus_rd = 1'b0;
        peek(4'h8, 32'h0, "R11 status zero after read");
    endtask

    task automatic shut();
        wr(4'h0, 32'hA500_0001);
        check(supply_en == 1'b0, "R2 supply drops after keyed write", {31'b0, supply_en}, 32'h0);
    endtask

    task automatic latency(input int pin, input logic lvl, input int exp, input string tag);
        int n = 0;
        wake_pin[pin] = lvl;
        while (!supply_en && n < 40000) begin
            cyc(); n++;
        end
        check(n == exp, tag, n, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cyc();
        // R1 reset state
        check(supply_en == 1'b1, "R1 supply on after reset", {31'b0, supply_en}, 32'h1);
        peek(4'h0, 32'h0, "R1 control reads zero");
        peek(4'h4, 32'h0, "R1 mode reads zero");
        peek(4'h8, 32'h0, "R1 status zero on plain power-on");
        peek(4'hC, 32'h0, "R1 wake input reg zero");

        // R4 / R5 register fields
        wr(4'h4, 32'hFFFF_FFFF);
        peek(4'h4, 32'h0702_0000, "R4 mode readback fields only");
        wr(4'hC, 32'h1234_ABCD);
        peek(4'hC, 32'h1234_ABCD, "R5 wake input readback");
        wr(4'h4, 32'h0); wr(4'hC, 32'h0);

        // R3 bad keys
        wr(4'h0, 32'h5A00_0001); cyc();
        check(supply_en == 1'b1, "R3 wrong key ignored", {31'b0, supply_en}, 32'h1);
        wr(4'h0, 32'hA500_0000); cyc();
        check(supply_en == 1'b1, "R3 bit0 clear ignored", {31'b0, supply_en}, 32'h1);

        // R10 activity while on sets nothing
        wr(4'h4, 32'h0002_0000); wr(4'hC, 32'h0001_0001);
        wake_pin[0] = 1'b1; rtc_alarm = 1'b1; cyc(); cyc();
        wake_pin[0] = 1'b0; rtc_alarm = 1'b0;
        peek(4'h8, 32'h0, "R10 no status while running");

        // R6 / R7 / R8: pin 3 active high, N = 3, with a restart
        wr(4'h4, 32'h0100_0000); wr(4'hC, 32'h0008_0008);
        shut();
        wake_pin[3] = 1'b1; cyc(); cyc();
        wake_pin[3] = 1'b0; cyc();
        check(supply_en == 1'b0, "R7 interrupted run does not wake", {31'b0, supply_en}, 32'h0);
        latency(3, 1'b1, 4, "R7 R6 full window after restart");
        read_clear(32'h0008_0000, "R8 status pin 3");
        wake_pin[3] = 1'b0;

        // R12 re-shutdown; R6 active-low pin 0, N = 32
        wake_pin[0] = 1'b1;
        wr(4'h4, 32'h0200_0000); wr(4'hC, 32'h0000_0001);
        cyc();
        shut();
        latency(0, 1'b0, 33, "R6 active low N=32");
        read_clear(32'h0001_0000, "R8 status pin 0");
        wake_pin[0] = 1'b0;

        // R10 disabled sources, then R9 RTC
        wr(4'h4, 32'h0); wr(4'hC, 32'hFFFF_0000);
        shut();
        wake_pin = 16'hFFFF; rtc_alarm = 1'b1;
        repeat (10) cyc();
        check(supply_en == 1'b0, "R10 disabled sources do not wake", {31'b0, supply_en}, 32'h0);
        wake_pin = '0;
        wr(4'h4, 32'h0002_0000);
        cyc();
        check(supply_en == 1'b1, "R9 RTC wake restores supply", {31'b0, supply_en}, 32'h1);
        rtc_alarm = 1'b0;
        read_clear(32'h0000_0020, "R9 status rtc bit 5");

        // R8 two pins at the same edge, N = 0
        wr(4'h4, 32'h0); wr(4'hC, 32'h0090_0090);
        shut();
        wake_pin[4] = 1'b1; wake_pin[7] = 1'b1; cyc();
        check(supply_en == 1'b1, "R6 N=0 wake in one edge", {31'b0, supply_en}, 32'h1);
        read_clear(32'h0090_0000, "R8 both pins recorded");
        wake_pin = '0;

        // R11 read collides with a new cause
        wr(4'hC, 32'h0002_0002);
        shut();
        bus_addr = 4'h8; bus_rd = 1'b1; wake_pin[1] = 1'b1;
        @(negedge clk);
        check(bus_rdata == 32'h0, "R11 old value during colliding read", bus_rdata, 32'h0);
        @(posedge clk); #1;
        bus_rd = 1'b0;
        peek(4'h8, 32'h0002_0000, "R11 new cause kept after read");
        read_clear(32'h0002_0000, "R11 cleared on second read");
        wake_pin = '0;

        // R6 longer windows
        wr(4'hC, 32'h0020_0020);
        wr(4'h4, 32'h0300_0000); cyc(); shut();
        latency(5, 1'b1, 513, "R6 N=512");
        wake_pin = '0;
        wr(4'h4, 32'h0400_0000); cyc(); shut();
        latency(5, 1'b1, 4097, "R6 N=4096");
        wake_pin = '0;
        wr(4'h4, 32'h0700_0000); cyc(); shut();
        latency(5, 1'b1, 32769, "R6 selector 7 acts as 32768");
        wake_pin = '0;
        read_clear(32'h0020_0000, "R8 status pin 5");

        repeat (3) cyc();
        finish_run();
    end

endmodule